// File: doc/BRIEF.md
# Event Time-Surface Feature Generator

This block turns a stream of pixel change events from an event camera into local time-surface patches. Each event gives a column, a row, a microsecond timestamp and a polarity bit. The polarity bit says whether the brightness at that pixel went up or down. The block keeps one last-timestamp memory for each polarity, with one word per pixel. For every accepted event it reads the square neighbourhood centred on the event's pixel from the memory that matches the event's polarity. For each neighbour it sends one 8-bit value that decays exponentially with the time since that neighbour last fired. After the last value of the patch has been handed over, it stores the event's timestamp at the centre pixel.

The block only works when an event arrives; it never produces periodic frames. Both the input and the output use valid/ready handshakes, and the block handles one event at a time. The decay is exp(-age/tau) in fixed point, taken from a 256-entry table filled at elaboration. The table index is the age shifted right by `SHIFT`, and the table covers ages up to 8·tau, with tau = 32·2^SHIFT µs.

The control is a four-state machine:
- `ST_IDLE` accepts an event and moves to `ST_FETCH`.
- `ST_FETCH` issues one memory read and always moves to `ST_EMIT`.
- `ST_EMIT` presents one patch value. When that value is accepted it goes back to `ST_FETCH` for the next neighbour, or to `ST_COMMIT` after the last neighbour.
- `ST_COMMIT` writes the centre timestamp and returns to `ST_IDLE`.

Top module: `event_time_surface`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every pixel of both polarity memories counts as never fired.
- R2: An event is taken when `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the whole patch has been sent and the centre timestamp has been written.
- R3: Each event yields exactly (2·RADIUS+1)² values, 25 by default, in raster order. Row offsets run from -RADIUS to +RADIUS, and within each row the column offsets run from -RADIUS to +RADIUS. `out_last` is 1 on the final value and 0 on all the others.
- R4: For a neighbour with a stored timestamp, let age = t_event − t_stored, as a wrapping 32-bit difference, and let i = age >> SHIFT with i < 256. The value is then within 1 of round(255·exp(−i/32)).
- R5: A neighbour that has never fired in the selected polarity memory outputs 0.
- R6: A neighbour whose age is 256·2^SHIFT µs (8·tau) or more outputs 0.
- R7: A neighbour whose column or row falls outside the sensor (below 0, or at 2^XW or 2^YW and beyond) outputs 0.
- R8: Polarity 0 and polarity 1 have separate memories. A patch reads only the memory of its own event's polarity, and the centre write goes only to that memory.
- R9: The centre value of a patch reflects the centre pixel's timestamp from before the current event. The new timestamp is written only after the last value has been accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_value` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event present |
| in_ready | output | 1 | Block can take an event |
| in_x | input | XW | Event column |
| in_y | input | YW | Event row |
| in_t | input | TW | Event timestamp in µs |
| in_pol | input | 1 | Event polarity (1 = brighter, 0 = darker) |
| out_valid | output | 1 | Patch value present |
| out_ready | input | 1 | Consumer takes the value |
| out_value | output | 8 | Decayed surface value |
| out_last | output | 1 | Final value of the patch |

## Verification
Some rules are checked by assertions on every cycle:
- the output value is held steady under back-pressure;
- the input and output sides are never active together;
- the centre write happens only right after the final value has been accepted;
- every patch has exactly the full neighbourhood count.

Other behaviour can only be shown by the bench's scenarios, because a property cannot express it:
- the numerical decay values;
- the raster order;
- zero output for edge, never-fired and stale neighbours;
- polarity separation;
- the centre reading the previous timestamp.

The bench checks these against a reference model of both memories built from the requirements.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int LUT_DEPTH = 256;
    localparam int VAL_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_EMIT   = 2'd2,
        ST_COMMIT = 2'd3
    } ts_state_e;

    // 255 * exp(-idx/32), evaluated in Q16 by repeated multiplication
    // with exp(-1/32) ~= 63520/65536.
    function automatic logic [VAL_W-1:0] decay_entry(input int unsigned idx);
        logic [47:0] acc;
        acc = 48'd255 << 16;
        for (int unsigned k = 0; k < idx; k++) begin
            acc = (acc * 48'd63520) >> 16;
        end
        acc = (acc + 48'd32768) >> 16;
        return acc[VAL_W-1:0];
    endfunction

endpackage

// File: rtl/ts_stamp_mem.sv
module ts_stamp_mem #(
    parameter int AW = 10,
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_pol,
    input  logic [AW-1:0] rd_addr,
    output logic [TW-1:0] rd_stamp,
    output logic          rd_seen,
    input  logic          wr_en,
    input  logic          wr_pol,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_stamp
);
    localparam int DEPTH = 1 << AW;

    logic [TW-1:0] bank_stamp [2];
    logic          bank_seen  [2];
    logic          pol_q;

    generate
        for (genvar p = 0; p < 2; p++) begin : g_bank
            logic [TW-1:0] stamps [DEPTH];
            logic [DEPTH-1:0] seen;

            always_ff @(posedge clk) begin
                if (wr_en && (wr_pol == p[0])) begin
                    stamps[wr_addr] <= wr_stamp;
                end
                if (rd_en) begin
                    bank_stamp[p] <= stamps[rd_addr];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seen         <= '0;
                    bank_seen[p] <= 1'b0;
                end else begin
                    if (wr_en && (wr_pol == p[0])) begin
                        seen[wr_addr] <= 1'b1;
                    end
                    if (rd_en) begin
                        bank_seen[p] <= seen[rd_addr];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (rd_en) begin
            pol_q <= rd_pol;
        end
    end

    assign rd_stamp = bank_stamp[pol_q];
    assign rd_seen  = bank_seen[pol_q];

    // R9
    no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);

endmodule

// File: rtl/ts_decay_lut.sv
module ts_decay_lut #(
    parameter int TW    = 32,
    parameter int SHIFT = 4
) (
    input  logic                    seen,
    input  logic [TW-1:0]           age,
    output logic [ts_pkg::VAL_W-1:0] value
);
    localparam int IDX_W = $clog2(ts_pkg::LUT_DEPTH);

    logic [ts_pkg::VAL_W-1:0] table_q [ts_pkg::LUT_DEPTH];
    logic [TW-1:0]            idx_full;
    logic                     stale;

    generate
        for (genvar g = 0; g < ts_pkg::LUT_DEPTH; g++) begin : g_lut
            assign table_q[g] = ts_pkg::decay_entry(g);
        end
    endgenerate

    assign idx_full = age >> SHIFT;
    assign stale    = |idx_full[TW-1:IDX_W];

    always_comb begin
        if (!seen || stale) begin
            value = '0;
        end else begin
            value = table_q[idx_full[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/ts_patch_fsm.sv
module ts_patch_fsm #(
    parameter int SIDE = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic                    out_last,
    output logic                    accept,
    output logic                    rd_en,
    output logic                    wr_en,
    output logic [$clog2(SIDE)-1:0] col,
    output logic [$clog2(SIDE)-1:0] row
);
    import ts_pkg::*;

    localparam int OW = $clog2(SIDE);
    localparam logic [OW-1:0] MAXO = OW'(SIDE - 1);

    ts_state_e state, state_nx;
    logic      at_end;

    assign at_end = (col == MAXO) && (row == MAXO);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_EMIT;
            ST_EMIT:   if (out_ready) state_nx = at_end ? ST_COMMIT : ST_FETCH;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            ST_IDLE:   in_ready  = 1'b1;
            ST_FETCH:  rd_en     = 1'b1;
            ST_EMIT:   out_valid = 1'b1;
            ST_COMMIT: wr_en     = 1'b1;
            default:   in_ready  = 1'b0;
        endcase
    end

    assign accept   = in_ready && in_valid;
    assign out_last = out_valid && at_end;

    // Raster offset counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (accept) begin
            col <= '0;
            row <= '0;
        end else if (out_valid && out_ready && !at_end) begin
            if (col == MAXO) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col <= MAXO) && (row <= MAXO));

endmodule

// File: rtl/event_time_surface.sv
module event_time_surface #(
    parameter int XW     = 5,
    parameter int YW     = 5,
    parameter int TW     = 32,
    parameter int RADIUS = 2,
    parameter int SHIFT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic [TW-1:0] in_t,
    input  logic          in_pol,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_value,
    output logic          out_last
);
    localparam int SIDE  = 2 * RADIUS + 1;
    localparam int PATCH = SIDE * SIDE;
    localparam int OW    = $clog2(SIDE);
    localparam int AW    = XW + YW;
    localparam int BW    = $clog2(PATCH + 1);
    localparam logic signed [XW+1:0] RAD_X = (XW+2)'(RADIUS);
    localparam logic signed [YW+1:0] RAD_Y = (YW+2)'(RADIUS);

    logic [XW-1:0] ev_x;
    logic [YW-1:0] ev_y;
    logic [TW-1:0] ev_t;
    logic          ev_pol;

    logic          accept, rd_en, wr_en;
    logic [OW-1:0] col, row;
    logic signed [XW+1:0] nx;
    logic signed [YW+1:0] ny;
    logic          inb, inb_q;
    logic [TW-1:0] rd_stamp;
    logic          rd_seen;
    logic [AW-1:0] rd_addr;

    ts_patch_fsm #(.SIDE(SIDE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .accept    (accept),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .col       (col),
        .row       (row)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_x   <= '0;
            ev_y   <= '0;
            ev_t   <= '0;
            ev_pol <= 1'b0;
        end else if (accept) begin
            ev_x   <= in_x;
            ev_y   <= in_y;
            ev_t   <= in_t;
            ev_pol <= in_pol;
        end
    end

    // Neighbour coordinates; the top two bits are zero only inside the sensor.
    assign nx  = $signed({2'b00, ev_x}) + $signed((XW+2)'(col)) - RAD_X;
    assign ny  = $signed({2'b00, ev_y}) + $signed((YW+2)'(row)) - RAD_Y;
    assign inb = (nx[XW+1:XW] == 2'b00) && (ny[YW+1:YW] == 2'b00);
    assign rd_addr = {ny[YW-1:0], nx[XW-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inb_q <= 1'b0;
        end else if (rd_en) begin
            inb_q <= inb;
        end
    end

    ts_stamp_mem #(.AW(AW), .TW(TW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_pol   (ev_pol),
        .rd_addr  (rd_addr),
        .rd_stamp (rd_stamp),
        .rd_seen  (rd_seen),
        .wr_en    (wr_en),
        .wr_pol   (ev_pol),
        .wr_addr  ({ev_y, ev_x}),
        .wr_stamp (ev_t)
    );

    ts_decay_lut #(.TW(TW), .SHIFT(SHIFT)) u_decay (
        .seen  (rd_seen && inb_q),
        .age   (ev_t - rd_stamp),
        .value (out_value)
    );

    // Independent beat counter for the checks below.
    logic [BW-1:0] beat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            beat_cnt <= '0;
        end else if (out_valid && out_ready) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    // R10
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_last)));

    // R2
    one_side_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R9
    write_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(out_valid && out_ready && out_last));

    // R3
    patch_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> (beat_cnt == BW'(PATCH - 1)));

endmodule

// File: tb/event_time_surface_test.sv
module event_time_surface_test;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 5, YW = 5, TW = 32, RADIUS = 2, SHIFT = 4;
    localparam int W = 1 << XW, H = 1 << YW, SIDE = 2 * RADIUS + 1;
    localparam int PATCH = SIDE * SIDE;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_pol = 1'b0, out_ready = 1'b0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [TW-1:0] in_t = '0;
    logic in_ready, out_valid, out_last;
    logic [7:0] out_value;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [TW-1:0] mdl_t [2][W*H];
    bit            mdl_v [2][W*H];

    event_time_surface #(.XW(XW), .YW(YW), .TW(TW), .RADIUS(RADIUS), .SHIFT(SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_t(in_t), .in_pol(in_pol),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int expect_value(input int pol, input int cx, input int cy,
                                        input logic [TW-1:0] t, input int beat);
        int nx, ny, a;
        logic [TW-1:0] age;
        logic [TW-1:0] idx;
        nx = cx + (beat % SIDE) - RADIUS;
        ny = cy + (beat / SIDE) - RADIUS;
        if (nx < 0 || nx >= W || ny < 0 || ny >= H) return 0;   // R7
        a = ny * W + nx;
        if (!mdl_v[pol][a]) return 0;                           // R5
        age = t - mdl_t[pol][a];
        idx = age >> SHIFT;
        if (idx >= 256) return 0;                               // R6
        return int'($floor(255.0 * $exp(-real'(idx) / 32.0) + 0.5)); // R4
    endfunction

    // Sends one event and checks its full patch; returns the centre value.
    task automatic send_event(input int x, input int y, input logic [TW-1:0] t,
                              input int pol, input int stall_pct, output int centre);
        int beat, guard, e, d;
        @(negedge clk);
        in_x = XW'(x); in_y = YW'(y); in_t = t; in_pol = pol[0]; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
        beat = 0; guard = 0; centre = -1;
        while (beat < PATCH && guard < 2000) begin
            out_ready = (($urandom % 100) >= stall_pct);
            #1;
            if (out_valid && out_ready) begin
                e = expect_value(pol, x, y, t, beat);
                d = int'(out_value) - e;
                check(d <= 1 && d >= -1, "R4/R5/R6/R7/R8/R9 value", int'(out_value), e);
                check(out_last == (beat == PATCH - 1), "R3 last flag", int'(out_last),
                      int'(beat == PATCH - 1));
                if (beat == PATCH / 2) centre = int'(out_value);
                beat++;
            end else if (out_valid) begin
                @(negedge clk); #1;
                check(out_valid == 1'b1, "R10 hold under stall", int'(out_valid), 1);
                continue;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        check(beat == PATCH, "R3 patch length", beat, PATCH);
        mdl_t[pol][y * W + x] = t;
        mdl_v[pol][y * W + x] = 1'b1;
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c;
        logic [TW-1:0] tnow;
        void'($urandom(32'd20260415));
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < W*H; a++) begin mdl_v[p][a] = 1'b0; mdl_t[p][a] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);

        // R1/R5/R7: first event at the corner, all zero
        send_event(0, 0, 32'd1000, 0, 0, c);
        check(c == 0, "R1 empty memory centre", c, 0);

        // R9/R4: same pixel again, centre reads previous stamp (idx 5 -> 218)
        send_event(0, 0, 32'd1080, 0, 30, c);
        check(c >= 217 && c <= 219, "R9 centre previous stamp", c, 218);

        // R8: opposite polarity at the same pixel sees nothing
        send_event(0, 0, 32'd1100, 1, 0, c);
        check(c == 0, "R8 polarity separation", c, 0);

        // R6: stale neighbour beyond 8 tau
        send_event(W-1, H-1, 32'd2000, 1, 20, c);
        send_event(W-1, H-1, 32'd2000 + 32'd4096, 1, 20, c);
        check(c == 0, "R6 stale centre", c, 0);

        // R4: zero age gives full scale
        send_event(W-1, H-1, 32'd6096, 1, 0, c);
        check(c == 255, "R4 zero age", c, 255);

        // Random cluster traffic with back-pressure
        tnow = 32'd10000;
        for (int n = 0; n < 300; n++) begin
            int x, y;
            if ($urandom % 8 == 0) begin
                x = ($urandom % 2) ? int'($urandom % 3) : W - 1 - int'($urandom % 3);
                y = ($urandom % 2) ? int'($urandom % 3) : H - 1 - int'($urandom % 3);
            end else begin
                x = 8 + int'($urandom % 8);
                y = 8 + int'($urandom % 8);
            end
            tnow = tnow + TW'($urandom % 300);
            send_event(x, y, tnow, int'($urandom % 2), 25, c);
        end

        finished = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule